// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

A combinational datapath block that forms the second operand of an ALU together with its shifter carry-out. A 32-bit value is moved left, right or around, or the immediate is passed through untouched. The shift amount comes either from a short field in the instruction or from the low byte of a register. The unit has no state, so result and carry follow the inputs in the same cycle.

Zero amounts, amounts of exactly the word width and amounts above it each have their own rules for every shift kind. The block is more than a plain barrel shifter because of these rules. A zero amount returns the operand unchanged and keeps the incoming carry. Logical shifts past the word width clear both the result and the carry. Arithmetic shifts past the word width saturate to the sign. Rotation wraps modulo the word width. The extended rotate always moves by exactly one place through the carry.

Top module: `opnd_shifter`

## Requirements
- R1: With source mode 0 (immediate), result_o equals imm_i and carry_o equals carry_i, whatever kind and amounts are applied.
- R2: Source mode 1 takes the amount from the 5-bit field shamt_imm_i, and source mode 2 takes it from the 8-bit field shamt_reg_i. The field that is not selected has no effect on the outputs.
- R3: For kinds 0 (logical left), 1 (logical right), 2 (arithmetic right) and 3 (rotate right), an amount of 0 returns operand_i unchanged, with carry_o equal to carry_i.
- R4: Kind 0, logical left, with amount n from 1 to 32 gives operand_i shifted left by n, with carry_o equal to operand bit 32-n. Any amount above 32 gives a result of 0 and a carry of 0.
- R5: Kind 1, logical right, with amount n from 1 to 32 gives operand_i shifted right by n with zero fill, with carry_o equal to operand bit n-1. Any amount above 32 gives a result of 0 and a carry of 0.
- R6: Kind 2, arithmetic right, with amount n from 1 to 31 fills the vacated bits with bit 31 and sets carry_o to operand bit n-1. Any amount of 32 or more gives 32 copies of bit 31, with carry_o equal to bit 31.
- R7: Kind 3, rotate right, with a nonzero amount rotates operand_i by the amount modulo 32, and carry_o equals bit 31 of the rotated value.
- R8: Kind 4, extended rotate, ignores the amount. It gives {carry_i, operand_i[31:1]}, with carry_o equal to operand_i[0].
- R9: Kinds 5 to 7 are treated as no shift: in modes 1 and 2, operand_i passes unchanged with carry_o equal to carry_i.
- R10: Source mode 3 is reserved. It drives result_o to all ones, with carry_o equal to carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Operand source: 0 immediate, 1 short-field amount, 2 register amount, 3 reserved |
| imm_i | input | DATA_W | Immediate value passed through in mode 0 |
| operand_i | input | DATA_W | Value to be shifted in modes 1 and 2 |
| kind_i | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 extended rotate |
| shamt_imm_i | input | IMM_AMT_W | Amount taken from the instruction field (mode 1) |
| shamt_reg_i | input | AMT_W | Amount taken from a register byte (mode 2) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | DATA_W | Shifted or passed operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They are only evaluated once every input is free of X and Z, so they assume the driver never leaves a field floating while the unit is in use. The bench drives all inputs to known values from time zero and changes them only between sample points. It sweeps every register amount from 0 to 255 and every short-field amount from 0 to 31, for all eight kind codes, both carry values and several operand patterns. It fills the unselected amount field with a value unrelated to the selected one, so that a wrong source choice shows up in the result.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;
  localparam logic [1:0] SRC_IMM = 2'd0;
  localparam logic [1:0] SRC_ISH = 2'd1;
  localparam logic [1:0] SRC_RSH = 2'd2;
  localparam logic [1:0] SRC_RSV = 2'd3;

  localparam logic [2:0] KIND_LSL = 3'd0;
  localparam logic [2:0] KIND_LSR = 3'd1;
  localparam logic [2:0] KIND_ASR = 3'd2;
  localparam logic [2:0] KIND_ROR = 3'd3;
  localparam logic [2:0] KIND_RRX = 3'd4;
endpackage

// File: rtl/opnd_amount_sel.sv
module opnd_amount_sel
  import opnd_shift_pkg::*;
#(
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5
) (
  input  logic [1:0]           mode_i,
  input  logic [IMM_AMT_W-1:0] shamt_imm_i,
  input  logic [AMT_W-1:0]     shamt_reg_i,
  output logic [AMT_W-1:0]     amt_o
);
  always_comb begin
    if (mode_i == SRC_ISH) amt_o = AMT_W'(shamt_imm_i);
    else                   amt_o = shamt_reg_i;
  end
endmodule

// File: rtl/opnd_linear_shift.sv
module opnd_linear_shift
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [2:0]        kind_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W) + 1;
  localparam int CW    = (AMT_W > LOG_W) ? AMT_W : LOG_W;

  logic [CW-1:0]            amt_w, amt_sat;
  logic [DATA_W:0]          left_ext, right_ext;
  logic signed [DATA_W:0]   arith_ext;

  assign amt_w   = CW'(amt_i);
  // arithmetic shift saturates at the word width: sign fill and sign carry
  assign amt_sat = (amt_w > CW'(DATA_W)) ? CW'(DATA_W) : amt_w;

  // one extra bit catches the last bit shifted out
  assign left_ext  = {1'b0, operand_i} << amt_w;
  assign right_ext = {operand_i, 1'b0} >> amt_w;
  assign arith_ext = $signed({operand_i, 1'b0}) >>> amt_sat;

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    if (amt_w != '0) begin
      case (kind_i)
        KIND_LSL: begin
          result_o = left_ext[DATA_W-1:0];
          carry_o  = left_ext[DATA_W];
        end
        KIND_LSR: begin
          result_o = right_ext[DATA_W:1];
          carry_o  = right_ext[0];
        end
        KIND_ASR: begin
          result_o = arith_ext[DATA_W:1];
          carry_o  = arith_ext[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/opnd_rotate.sv
module opnd_rotate #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              rrx_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W) + 1;
  localparam int CW    = (AMT_W > LOG_W) ? AMT_W : LOG_W;

  logic [CW-1:0]     amt_w, rot_amt;
  logic [DATA_W-1:0] rotated;

  assign amt_w   = CW'(amt_i);
  assign rot_amt = amt_w % CW'(DATA_W);
  // rot_amt == 0 makes the left term shift out completely
  assign rotated = (operand_i >> rot_amt) | (operand_i << (CW'(DATA_W) - rot_amt));

  always_comb begin
    if (rrx_i) begin
      result_o = {carry_i, operand_i[DATA_W-1:1]};
      carry_o  = operand_i[0];
    end else if (amt_w == '0) begin
      result_o = operand_i;
      carry_o  = carry_i;
    end else begin
      result_o = rotated;
      carry_o  = rotated[DATA_W-1];
    end
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5
) (
  input  logic [1:0]           mode_i,
  input  logic [DATA_W-1:0]    imm_i,
  input  logic [DATA_W-1:0]    operand_i,
  input  logic [2:0]           kind_i,
  input  logic [IMM_AMT_W-1:0] shamt_imm_i,
  input  logic [AMT_W-1:0]     shamt_reg_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    result_o,
  output logic                 carry_o
);
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] lin_res, rot_res;
  logic              lin_c, rot_c;

  opnd_amount_sel #(.AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W)) u_amt (
    .mode_i      (mode_i),
    .shamt_imm_i (shamt_imm_i),
    .shamt_reg_i (shamt_reg_i),
    .amt_o       (amt)
  );

  opnd_linear_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lin (
    .kind_i    (kind_i),
    .operand_i (operand_i),
    .amt_i     (amt),
    .carry_i   (carry_i),
    .result_o  (lin_res),
    .carry_o   (lin_c)
  );

  opnd_rotate #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
    .rrx_i     (kind_i == KIND_RRX),
    .operand_i (operand_i),
    .amt_i     (amt),
    .carry_i   (carry_i),
    .result_o  (rot_res),
    .carry_o   (rot_c)
  );

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    case (mode_i)
      SRC_IMM: result_o = imm_i;
      SRC_RSV: result_o = '1;
      default: begin
        if (kind_i == KIND_LSL || kind_i == KIND_LSR || kind_i == KIND_ASR) begin
          result_o = lin_res;
          carry_o  = lin_c;
        end else if (kind_i == KIND_ROR || kind_i == KIND_RRX) begin
          result_o = rot_res;
          carry_o  = rot_c;
        end
      end
    endcase
  end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5
) (
  input logic [1:0]           mode_i,
  input logic [DATA_W-1:0]    imm_i,
  input logic [DATA_W-1:0]    operand_i,
  input logic [2:0]           kind_i,
  input logic [IMM_AMT_W-1:0] shamt_imm_i,
  input logic [AMT_W-1:0]     shamt_reg_i,
  input logic                 carry_i,
  input logic [DATA_W-1:0]    result_o,
  input logic                 carry_o
);
  int  eff;
  logic known, shifting;

  always_comb begin
    known = !$isunknown({mode_i, imm_i, operand_i, kind_i, shamt_imm_i,
                         shamt_reg_i, carry_i, result_o, carry_o});
    shifting = (mode_i == 2'd1) || (mode_i == 2'd2);
    eff = (mode_i == 2'd1) ? int'(shamt_imm_i) : int'(shamt_reg_i);
    if (known) begin
      if (mode_i == 2'd0)
        a_r1_imm_pass: assert (result_o == imm_i && carry_o == carry_i);
      if (mode_i == 2'd3)
        a_r10_reserved_ones: assert (result_o == '1 && carry_o == carry_i);
      if (shifting && kind_i < 3'd4 && eff == 0)
        a_r3_zero_amount: assert (result_o == operand_i && carry_o == carry_i);
      if (shifting && (kind_i == 3'd0 || kind_i == 3'd1) && eff > DATA_W)
        a_r4_r5_logical_clear: assert (result_o == '0 && carry_o == 1'b0);
      if (shifting && kind_i == 3'd2 && eff >= DATA_W)
        a_r6_arith_saturate: assert (result_o == {DATA_W{operand_i[DATA_W-1]}}
                                     && carry_o == operand_i[DATA_W-1]);
      if (shifting && kind_i == 3'd3 && eff != 0)
        a_r7_rotate_carry: assert (carry_o == result_o[DATA_W-1]
                                   && $countones(result_o) == $countones(operand_i));
      if (shifting && kind_i == 3'd4)
        a_r8_extended_rotate: assert (result_o == {carry_i, operand_i[DATA_W-1:1]}
                                      && carry_o == operand_i[0]);
      if (shifting && kind_i > 3'd4)
        a_r9_undefined_kind: assert (result_o == operand_i && carry_o == carry_i);
    end
  end
endmodule

bind opnd_shifter opnd_shifter_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W)
) u_chk (
  .mode_i      (mode_i),
  .imm_i       (imm_i),
  .operand_i   (operand_i),
  .kind_i      (kind_i),
  .shamt_imm_i (shamt_imm_i),
  .shamt_reg_i (shamt_reg_i),
  .carry_i     (carry_i),
  .result_o    (result_o),
  .carry_o     (carry_o)
);

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;
  localparam int DATA_W = 32;
  localparam int AMT_W = 8;
  localparam int IMM_AMT_W = 5;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]           mode_i = 2'd0;
  logic [DATA_W-1:0]    imm_i = '0;
  logic [DATA_W-1:0]    operand_i = '0;
  logic [2:0]           kind_i = 3'd0;
  logic [IMM_AMT_W-1:0] shamt_imm_i = '0;
  logic [AMT_W-1:0]     shamt_reg_i = '0;
  logic                 carry_i = 1'b0;
  logic [DATA_W-1:0]    result_o;
  logic                 carry_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  opnd_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W)) u0 (
    .mode_i(mode_i), .imm_i(imm_i), .operand_i(operand_i), .kind_i(kind_i),
    .shamt_imm_i(shamt_imm_i), .shamt_reg_i(shamt_reg_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  // bit-serial reference: one position per step
  function automatic logic [DATA_W:0] ref_shift(input logic [2:0] k, input logic [DATA_W-1:0] v0,
                                                input int n, input logic c0);
    logic [DATA_W-1:0] v = v0;
    logic c = c0;
    if (k == 3'd4) return {v0[0], c0, v0[DATA_W-1:1]};
    if (k > 3'd4 || n == 0) return {c0, v0};
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = v[DATA_W-1]; v = {v[DATA_W-2:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = v[0]; v = {1'b0, v[DATA_W-1:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[DATA_W-1], v[DATA_W-1:1]}; end
      default: begin
        for (int i = 0; i < n % DATA_W; i++) v = {v[0], v[DATA_W-1:1]};
        c = v[DATA_W-1];
      end
    endcase
    return {c, v};
  endfunction

  function automatic string tag_of(input logic [2:0] k, input int n);
    if (k < 3'd4 && n == 0) return "R3";
    case (k)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] exp_r, input logic exp_c);
    checks++;
    if (result_o !== exp_r || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s: mode=%0d kind=%0d op=%h got r=%h c=%b exp r=%h c=%b",
               tag, mode_i, kind_i, operand_i, result_o, carry_o, exp_r, exp_c);
    end
  endtask

  task automatic apply_and_check(input string tag, input logic [DATA_W-1:0] exp_r, input logic exp_c);
    #5;
    check(tag, exp_r, exp_c);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles exp <= %0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [DATA_W-1:0] pats [6] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF,
                                  32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF};

  initial begin
    logic [DATA_W:0] e;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    apply_and_check("R1", '0, 1'b0);

    // R1 immediate pass-through, shift fields set to disturb
    for (int p = 0; p < 6; p++) begin
      mode_i = 2'd0; imm_i = ~pats[p]; operand_i = pats[p]; kind_i = 3'(p);
      shamt_imm_i = 5'(p + 3); shamt_reg_i = 8'(p * 40 + 1); carry_i = p[0];
      apply_and_check("R1", ~pats[p], p[0]);
      // R10 reserved mode
      mode_i = 2'd3;
      apply_and_check("R10", '1, p[0]);
    end

    // register amount sweep (R2 via unrelated short field)
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 256; n++)
          for (int c = 0; c < 2; c++) begin
            mode_i = 2'd2; operand_i = pats[p]; kind_i = 3'(k);
            shamt_reg_i = 8'(n); shamt_imm_i = ~5'(n + 7); carry_i = c[0];
            e = ref_shift(3'(k), pats[p], n, c[0]);
            apply_and_check(tag_of(3'(k), n), e[DATA_W-1:0], e[DATA_W]);
          end

    // short-field amount sweep, register field holds a large unrelated value (R2)
    for (int p = 2; p < 6; p++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++) begin
            mode_i = 2'd1; operand_i = pats[p]; kind_i = 3'(k);
            shamt_imm_i = 5'(n); shamt_reg_i = 8'(200 + n); carry_i = c[0];
            e = ref_shift(3'(k), pats[p], n, c[0]);
            apply_and_check("R2", e[DATA_W-1:0], e[DATA_W]);
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule